// File: doc/BRIEF.md
# Processor Trap Entry Controller

This block is the trap-entry stage of a small 32-bit soft processor. Each cycle it looks at three request sources: a hardware exception (which includes address-translation faults), a break (hardware or software), and an external interrupt. It also reads the current PC, the machine status register, the delay-slot and immediate-prefix flags, and the pending branch target. When it accepts one event, it computes the redirected PC and a set of write-backs: the link general register, the status register, the exception syndrome, the fault address and the saved branch target. These are presented, one cycle later, as registered values, each with its own write enable. The surrounding pipeline applies them to its register file and special registers.

Every accepted entry moves the live translation-enable and user-mode bits one place up into their shadow copies and clears the live bits. The handler therefore starts privileged and untranslated. A fault raised in a delay slot is marked so that the branch can be re-executed. A translation fault that arrives while the previous cause is already a translation fault stops the block with a sticky abort instead of entering again. An exception cause code that is not recognised raises a sticky error and writes nothing.

Top module: `trap_entry_ctrl`

## Requirements
- R1: An accepted hardware exception writes the current PC to general register 17, sets the exception-in-progress status bit (bit 9) and redirects the PC to 0x20.
- R2: An accepted interrupt writes the current PC to general register 14 and redirects the PC to 0x10. It sets neither in-progress bit.
- R3: A hardware break (`brk_hw`=1) writes the current PC to general register 16, sets the break-in-progress bit (bit 3) and redirects the PC to 0x18.
- R4: A software break (`brk_hw`=0) redirects the PC to the pending branch target, sets break-in-progress and writes no general register.
- R5: On every entry, status bit 13 (translation enable) is copied to bit 14 and bit 11 (user mode) is copied to bit 12. Bits 13 and 11 are then cleared. All other status bits pass through unchanged.
- R6: An exception taken with the delay-slot flag set does three things: it sets syndrome bit 12, writes the pending branch target to the branch-target register, and saves PC-4 as the link value.
- R7: A hardware exception asserts `flags_clr`, which clears the delay-slot and immediate-prefix flags. Interrupts and breaks do not assert it.
- R8: Cause 1 is a fault of the first class: syndrome 16 for a data access and 17 for a fetch. Cause 2 is a fault of the second class: 18 for data and 19 for a fetch. For either fault, syndrome bit 10 marks a store, and the fault address is written to the address register. Cause 0 is a generic exception: its syndrome is `gen_code`, and the address register is not written.
- R9: A fault (cause 1 or 2) arriving while `prev_fault` is set raises `abort`. No entry happens, `abort` stays set until reset, and it blocks all later entries.
- R10: An interrupt is accepted only when status bit 1 (interrupt enable) is set, bits 9 and 3 are clear, and the delay-slot flag is clear.
- R11: When several requests arrive together, a hardware exception wins over a break, and a break wins over an interrupt. Exactly one one-cycle taken strobe is asserted per entry.
- R12: A cause code of 3 to 7 sets the sticky `bad_code` output. No write enable is raised in that cycle, and no other request is served in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Hardware exception request |
| exc_cause | input | 3 | 0 generic, 1 first fault class, 2 second fault class |
| exc_fetch | input | 1 | Fault was an instruction fetch |
| exc_store | input | 1 | Fault was a store |
| exc_addr | input | 32 | Faulting address |
| gen_code | input | 5 | Syndrome for a generic exception |
| prev_fault | input | 1 | Previous pending cause was a translation fault |
| brk_req | input | 1 | Break request |
| brk_hw | input | 1 | Break is hardware (1) or software (0) |
| irq_req | input | 1 | External interrupt request |
| cur_pc | input | 32 | Current PC |
| cur_msr | input | 32 | Current status register |
| flag_ds | input | 1 | In delay slot |
| flag_imm | input | 1 | Immediate prefix pending |
| br_target | input | 32 | Pending branch target |
| taken_exc | output | 1 | Exception entered (one cycle) |
| taken_brk | output | 1 | Break entered (one cycle) |
| taken_irq | output | 1 | Interrupt entered (one cycle) |
| pc_we | output | 1 | PC write enable |
| pc_next | output | 32 | New PC |
| gpr_we | output | 1 | Link register write enable |
| gpr_idx | output | 5 | Link register index |
| gpr_data | output | 32 | Link value |
| msr_we | output | 1 | Status write enable |
| msr_next | output | 32 | New status value |
| esr_we | output | 1 | Syndrome write enable |
| esr_next | output | 32 | New syndrome |
| ear_we | output | 1 | Fault address write enable |
| ear_next | output | 32 | Fault address |
| btr_we | output | 1 | Branch-target register write enable |
| btr_next | output | 32 | Saved branch target |
| flags_clr | output | 1 | Clear delay-slot and immediate flags |
| abort | output | 1 | Sticky recursive-fault abort |
| bad_code | output | 1 | Sticky unknown-cause error |

## Verification
The assertions rely on two things about the inputs. First, a request is held for exactly one cycle, so each registered output belongs to the inputs of the cycle before it. Second, the status and flag inputs are meaningful whenever a request is present. The bench drives every request for a single cycle and then returns all requests to zero, so each result is observed in isolation. The recursive-fault and unknown-cause cases are run last, each followed by a reset, so their sticky outputs cannot hide the other cases.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {EV_NONE = 2'd0, EV_EXC = 2'd1, EV_BRK = 2'd2, EV_IRQ = 2'd3} ev_kind_e;

  localparam logic [2:0] CAUSE_GEN   = 3'd0;
  localparam logic [2:0] CAUSE_FLT_A = 3'd1;
  localparam logic [2:0] CAUSE_FLT_B = 3'd2;

  // status register bit positions; shadow bits sit one above their live bits
  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_UMS = 12;
  localparam int MSR_VM  = 13;
  localparam int MSR_VMS = 14;

  // syndrome bit positions
  localparam int ESR_STORE = 10;
  localparam int ESR_DS    = 12;
endpackage

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
(
  input  logic       exc_req,
  input  logic [2:0] exc_cause,
  input  logic       prev_fault,
  input  logic       brk_req,
  input  logic       irq_req,
  input  logic       irq_ok,
  input  logic       halted,
  output ev_kind_e   kind,
  output logic       is_fault,
  output logic       bad,
  output logic       recur
);
  logic cause_known;

  always_comb begin
    cause_known = (exc_cause == CAUSE_GEN) || (exc_cause == CAUSE_FLT_A) ||
                  (exc_cause == CAUSE_FLT_B);
    is_fault    = (exc_cause == CAUSE_FLT_A) || (exc_cause == CAUSE_FLT_B);
    kind  = EV_NONE;
    bad   = 1'b0;
    recur = 1'b0;
    if (!halted) begin
      if (exc_req) begin
        if (!cause_known)               bad   = 1'b1;
        else if (is_fault && prev_fault) recur = 1'b1;
        else                            kind  = EV_EXC;
      end else if (brk_req) begin
        kind = EV_BRK;
      end else if (irq_req && irq_ok) begin
        kind = EV_IRQ;
      end
    end
  end
endmodule

// File: rtl/trap_msr_update.sv
module trap_msr_update
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] msr_in,
  input  ev_kind_e        kind,
  output logic [XLEN-1:0] msr_out
);
  always_comb begin
    msr_out          = msr_in;
    msr_out[MSR_VMS] = msr_in[MSR_VM];
    msr_out[MSR_UMS] = msr_in[MSR_UM];
    msr_out[MSR_VM]  = 1'b0;
    msr_out[MSR_UM]  = 1'b0;
    if (kind == EV_EXC) msr_out[MSR_EIP] = 1'b1;
    if (kind == EV_BRK) msr_out[MSR_BIP] = 1'b1;
  end
endmodule

// File: rtl/trap_syndrome.sv
module trap_syndrome
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic [2:0]        exc_cause,
  input  logic              exc_fetch,
  input  logic              exc_store,
  input  logic              in_ds,
  input  logic [CODE_W-1:0] gen_code,
  output logic [XLEN-1:0]   esr
);
  logic [CODE_W-1:0] code;

  always_comb begin
    unique case (exc_cause)
      CAUSE_FLT_A: code = exc_fetch ? CODE_W'(17) : CODE_W'(16);
      CAUSE_FLT_B: code = exc_fetch ? CODE_W'(19) : CODE_W'(18);
      default:     code = gen_code;
    endcase
    esr = XLEN'(code);
    if ((exc_cause == CAUSE_FLT_A) || (exc_cause == CAUSE_FLT_B))
      esr[ESR_STORE] = exc_store;
    esr[ESR_DS] = in_ds;
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              REG_W    = 5,
  parameter int              CODE_W   = 5,
  parameter logic [XLEN-1:0] EXC_VEC  = 32'h20,
  parameter logic [XLEN-1:0] IRQ_VEC  = 32'h10,
  parameter logic [XLEN-1:0] BRK_VEC  = 32'h18,
  parameter int              EXC_LINK = 17,
  parameter int              IRQ_LINK = 14,
  parameter int              BRK_LINK = 16,
  parameter int              INSN_B   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_req,
  input  logic [2:0]        exc_cause,
  input  logic              exc_fetch,
  input  logic              exc_store,
  input  logic [XLEN-1:0]   exc_addr,
  input  logic [CODE_W-1:0] gen_code,
  input  logic              prev_fault,
  input  logic              brk_req,
  input  logic              brk_hw,
  input  logic              irq_req,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_msr,
  input  logic              flag_ds,
  input  logic              flag_imm,
  input  logic [XLEN-1:0]   br_target,
  output logic              taken_exc,
  output logic              taken_brk,
  output logic              taken_irq,
  output logic              pc_we,
  output logic [XLEN-1:0]   pc_next,
  output logic              gpr_we,
  output logic [REG_W-1:0]  gpr_idx,
  output logic [XLEN-1:0]   gpr_data,
  output logic              msr_we,
  output logic [XLEN-1:0]   msr_next,
  output logic              esr_we,
  output logic [XLEN-1:0]   esr_next,
  output logic              ear_we,
  output logic [XLEN-1:0]   ear_next,
  output logic              btr_we,
  output logic [XLEN-1:0]   btr_next,
  output logic              flags_clr,
  output logic              abort,
  output logic              bad_code
);
  localparam logic [XLEN-1:0] INSN_STEP = XLEN'(INSN_B);

  ev_kind_e        kind;
  logic            is_fault, bad, recur, irq_ok;
  logic [XLEN-1:0] msr_upd, esr_upd, link_val;

  // immediate-prefix flag is only consumed by the pipeline through flags_clr
  logic unused_imm;
  assign unused_imm = flag_imm;

  assign irq_ok = cur_msr[MSR_IE] && !cur_msr[MSR_EIP] && !cur_msr[MSR_BIP] && !flag_ds;

  trap_select u_sel (
    .exc_req    (exc_req),
    .exc_cause  (exc_cause),
    .prev_fault (prev_fault),
    .brk_req    (brk_req),
    .irq_req    (irq_req),
    .irq_ok     (irq_ok),
    .halted     (abort),
    .kind       (kind),
    .is_fault   (is_fault),
    .bad        (bad),
    .recur      (recur)
  );

  trap_msr_update #(.XLEN(XLEN)) u_msr (
    .msr_in  (cur_msr),
    .kind    (kind),
    .msr_out (msr_upd)
  );

  trap_syndrome #(.XLEN(XLEN), .CODE_W(CODE_W)) u_syn (
    .exc_cause (exc_cause),
    .exc_fetch (exc_fetch),
    .exc_store (exc_store),
    .in_ds     (flag_ds),
    .gen_code  (gen_code),
    .esr       (esr_upd)
  );

  // a fault inside a delay slot re-executes the branch before it
  assign link_val = (kind == EV_EXC && flag_ds) ? cur_pc - INSN_STEP : cur_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_exc <= 1'b0;
      taken_brk <= 1'b0;
      taken_irq <= 1'b0;
      pc_we     <= 1'b0;
      pc_next   <= '0;
      gpr_we    <= 1'b0;
      gpr_idx   <= '0;
      gpr_data  <= '0;
      msr_we    <= 1'b0;
      msr_next  <= '0;
      esr_we    <= 1'b0;
      esr_next  <= '0;
      ear_we    <= 1'b0;
      ear_next  <= '0;
      btr_we    <= 1'b0;
      btr_next  <= '0;
      flags_clr <= 1'b0;
      abort     <= 1'b0;
      bad_code  <= 1'b0;
    end else begin
      taken_exc <= (kind == EV_EXC);
      taken_brk <= (kind == EV_BRK);
      taken_irq <= (kind == EV_IRQ);
      pc_we     <= (kind != EV_NONE);
      msr_we    <= (kind != EV_NONE);
      msr_next  <= msr_upd;
      gpr_data  <= link_val;
      esr_we    <= (kind == EV_EXC);
      esr_next  <= esr_upd;
      ear_we    <= (kind == EV_EXC) && is_fault;
      ear_next  <= exc_addr;
      btr_we    <= (kind == EV_EXC) && flag_ds;
      btr_next  <= br_target;
      flags_clr <= (kind == EV_EXC);
      abort     <= abort | recur;
      bad_code  <= bad_code | bad;
      unique case (kind)
        EV_EXC: begin
          pc_next <= EXC_VEC;
          gpr_we  <= 1'b1;
          gpr_idx <= REG_W'(EXC_LINK);
        end
        EV_IRQ: begin
          pc_next <= IRQ_VEC;
          gpr_we  <= 1'b1;
          gpr_idx <= REG_W'(IRQ_LINK);
        end
        EV_BRK: begin
          pc_next <= brk_hw ? BRK_VEC : br_target;
          gpr_we  <= brk_hw;
          gpr_idx <= REG_W'(BRK_LINK);
        end
        default: begin
          pc_next <= pc_next;
          gpr_we  <= 1'b0;
          gpr_idx <= gpr_idx;
        end
      endcase
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              REG_W    = 5,
  parameter logic [XLEN-1:0] EXC_VEC  = 32'h20,
  parameter logic [XLEN-1:0] IRQ_VEC  = 32'h10,
  parameter logic [XLEN-1:0] BRK_VEC  = 32'h18,
  parameter int              EXC_LINK = 17,
  parameter int              IRQ_LINK = 14,
  parameter int              BRK_LINK = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [XLEN-1:0]  cur_msr,
  input logic             flag_ds,
  input logic             taken_exc,
  input logic             taken_brk,
  input logic             taken_irq,
  input logic             pc_we,
  input logic [XLEN-1:0]  pc_next,
  input logic             gpr_we,
  input logic [REG_W-1:0] gpr_idx,
  input logic             msr_we,
  input logic [XLEN-1:0]  msr_next,
  input logic             abort,
  input logic             bad_code
);
  a_r1_exc_entry: assert property (@(posedge clk) disable iff (rst)
    taken_exc |-> (pc_we && pc_next == EXC_VEC && gpr_we &&
                   gpr_idx == REG_W'(EXC_LINK) && msr_next[MSR_EIP]));

  a_r2_irq_entry: assert property (@(posedge clk) disable iff (rst)
    taken_irq |-> (pc_we && pc_next == IRQ_VEC && gpr_idx == REG_W'(IRQ_LINK)));

  a_r3_hw_break: assert property (@(posedge clk) disable iff (rst)
    (taken_brk && gpr_we) |-> (pc_next == BRK_VEC && gpr_idx == REG_W'(BRK_LINK) &&
                               msr_next[MSR_BIP]));

  a_r5_live_cleared: assert property (@(posedge clk) disable iff (rst)
    msr_we |-> (!msr_next[MSR_VM] && !msr_next[MSR_UM]));

  a_r5_shadow_copy: assert property (@(posedge clk) disable iff (rst)
    msr_we |-> (msr_next[MSR_VMS] == $past(cur_msr[MSR_VM]) &&
                msr_next[MSR_UMS] == $past(cur_msr[MSR_UM])));

  a_r10_irq_gate: assert property (@(posedge clk) disable iff (rst)
    taken_irq |-> $past(cur_msr[MSR_IE] && !cur_msr[MSR_EIP] &&
                        !cur_msr[MSR_BIP] && !flag_ds));

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({taken_exc, taken_brk, taken_irq}));

  a_r9_abort_sticky: assert property (@(posedge clk) disable iff (rst)
    abort |=> abort);

  a_r12_bad_sticky: assert property (@(posedge clk) disable iff (rst)
    bad_code |=> bad_code);

  a_r12_no_write: assert property (@(posedge clk) disable iff (rst)
    $rose(bad_code) |-> (!pc_we && !msr_we && !gpr_we));
endmodule

bind trap_entry_ctrl trap_entry_chk #(
  .XLEN(XLEN), .REG_W(REG_W), .EXC_VEC(EXC_VEC), .IRQ_VEC(IRQ_VEC), .BRK_VEC(BRK_VEC),
  .EXC_LINK(EXC_LINK), .IRQ_LINK(IRQ_LINK), .BRK_LINK(BRK_LINK)
) u_chk (
  .clk(clk), .rst(rst), .cur_msr(cur_msr), .flag_ds(flag_ds),
  .taken_exc(taken_exc), .taken_brk(taken_brk), .taken_irq(taken_irq),
  .pc_we(pc_we), .pc_next(pc_next), .gpr_we(gpr_we), .gpr_idx(gpr_idx),
  .msr_we(msr_we), .msr_next(msr_next), .abort(abort), .bad_code(bad_code)
);

// File: tb/sim_trap_entry_ctrl.sv
module sim_trap_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        exc_req, exc_fetch, exc_store, prev_fault, brk_req, brk_hw, irq_req;
  logic [2:0]  exc_cause;
  logic [31:0] exc_addr, cur_pc, cur_msr, br_target;
  logic [4:0]  gen_code;
  logic        flag_ds, flag_imm;
  logic        taken_exc, taken_brk, taken_irq, pc_we, gpr_we, msr_we, esr_we;
  logic        ear_we, btr_we, flags_clr, abort, bad_code;
  logic [31:0] pc_next, gpr_data, msr_next, esr_next, ear_next, btr_next;
  logic [4:0]  gpr_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [31:0] PC0  = 32'h0000_0100;
  localparam logic [31:0] BT0  = 32'h0000_4000;
  localparam logic [31:0] ADR0 = 32'h1234_5678;

  always #5 clk = ~clk;

  trap_entry_ctrl u0 (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_cause(exc_cause),
    .exc_fetch(exc_fetch), .exc_store(exc_store), .exc_addr(exc_addr),
    .gen_code(gen_code), .prev_fault(prev_fault), .brk_req(brk_req),
    .brk_hw(brk_hw), .irq_req(irq_req), .cur_pc(cur_pc), .cur_msr(cur_msr),
    .flag_ds(flag_ds), .flag_imm(flag_imm), .br_target(br_target),
    .taken_exc(taken_exc), .taken_brk(taken_brk), .taken_irq(taken_irq),
    .pc_we(pc_we), .pc_next(pc_next), .gpr_we(gpr_we), .gpr_idx(gpr_idx),
    .gpr_data(gpr_data), .msr_we(msr_we), .msr_next(msr_next),
    .esr_we(esr_we), .esr_next(esr_next), .ear_we(ear_we), .ear_next(ear_next),
    .btr_we(btr_we), .btr_next(btr_next), .flags_clr(flags_clr),
    .abort(abort), .bad_code(bad_code)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        exc;
    logic [2:0]  cause;
    logic        fetch;
    logic        store;
    logic        brk;
    logic        bhw;
    logic        irq;
    logic        ds;
    logic [15:0] msr;
    logic [1:0]  kind;   // 0 none, 1 exception, 2 break, 3 interrupt
    logic [31:0] epc;
    logic        gwe;
    logic [4:0]  gidx;
    logic [31:0] gdata;
    logic [15:0] emsr;
    logic        ewe;
    logic [15:0] eesr;
    logic        earwe;
    logic        btrwe;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    // R1 generic exception, R5 shadows from VM and UM
    '{4'd1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2802, 2'd1, 32'h20, 1'b1, 5'd17, 32'h100, 16'h5202, 1'b1, 16'h0005, 1'b0, 1'b0},
    // R8 first class, data load
    '{4'd8, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0002, 2'd1, 32'h20, 1'b1, 5'd17, 32'h100, 16'h0202, 1'b1, 16'h0010, 1'b1, 1'b0},
    // R8 first class, fetch
    '{4'd8, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2000, 2'd1, 32'h20, 1'b1, 5'd17, 32'h100, 16'h4200, 1'b1, 16'h0011, 1'b1, 1'b0},
    // R8 second class, data store
    '{4'd8, 1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0800, 2'd1, 32'h20, 1'b1, 5'd17, 32'h100, 16'h1200, 1'b1, 16'h0412, 1'b1, 1'b0},
    // R6 second class fetch in delay slot
    '{4'd6, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 2'd1, 32'h20, 1'b1, 5'd17, 32'h0FC, 16'h0200, 1'b1, 16'h1013, 1'b1, 1'b1},
    // R2 interrupt accepted
    '{4'd2, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h2802, 2'd3, 32'h10, 1'b1, 5'd14, 32'h100, 16'h5002, 1'b0, 16'h0000, 1'b0, 1'b0},
    // R10 blocked: enable clear
    '{4'd10, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 2'd0, 32'h0, 1'b0, 5'd0, 32'h0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0},
    // R10 blocked: exception in progress
    '{4'd10, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0202, 2'd0, 32'h0, 1'b0, 5'd0, 32'h0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0},
    // R10 blocked: delay slot
    '{4'd10, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0002, 2'd0, 32'h0, 1'b0, 5'd0, 32'h0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0},
    // R10 blocked: break in progress
    '{4'd10, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h000A, 2'd0, 32'h0, 1'b0, 5'd0, 32'h0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0},
    // R3 hardware break
    '{4'd3, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0800, 2'd2, 32'h18, 1'b1, 5'd16, 32'h100, 16'h1008, 1'b0, 16'h0000, 1'b0, 1'b0},
    // R4 software break
    '{4'd4, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h2000, 2'd2, 32'h4000, 1'b0, 5'd0, 32'h0, 16'h4008, 1'b0, 16'h0000, 1'b0, 1'b0},
    // R11 all three at once: exception wins
    '{4'd11, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0002, 2'd1, 32'h20, 1'b1, 5'd17, 32'h100, 16'h0202, 1'b1, 16'h0005, 1'b0, 1'b0},
    // R11 break beats interrupt
    '{4'd11, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0002, 2'd2, 32'h18, 1'b1, 5'd16, 32'h100, 16'h000A, 1'b0, 16'h0000, 1'b0, 1'b0}
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    exc_req = 0; exc_cause = 0; exc_fetch = 0; exc_store = 0; prev_fault = 0;
    brk_req = 0; brk_hw = 0; irq_req = 0; flag_ds = 0; flag_imm = 0;
    cur_msr = 0; cur_pc = PC0; br_target = BT0; exc_addr = ADR0; gen_code = 5'd5;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; idle_inputs();
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic pulse_then_idle();
    @(negedge clk);   // registered result of the previous cycle's request
  endtask

  initial begin
    rst = 1;
    idle_inputs();
    do_reset();

    // reset state
    chk(11, "strobes after reset", {29'd0, taken_exc, taken_brk, taken_irq}, 32'd0);
    chk(12, "pc_we after reset", {31'd0, pc_we}, 32'd0);
    chk(9, "abort after reset", {30'd0, abort, bad_code}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      exc_req = TBL[i].exc; exc_cause = TBL[i].cause; exc_fetch = TBL[i].fetch;
      exc_store = TBL[i].store; brk_req = TBL[i].brk; brk_hw = TBL[i].bhw;
      irq_req = TBL[i].irq; flag_ds = TBL[i].ds; cur_msr = {16'd0, TBL[i].msr};
      pulse_then_idle();
      chk(int'(TBL[i].req), "strobes", {29'd0, taken_exc, taken_brk, taken_irq},
          {29'd0, TBL[i].kind == 2'd1, TBL[i].kind == 2'd2, TBL[i].kind == 2'd3});
      chk(int'(TBL[i].req), "pc_we", {31'd0, pc_we}, {31'd0, TBL[i].kind != 2'd0});
      chk(int'(TBL[i].req), "gpr_we", {31'd0, gpr_we}, {31'd0, TBL[i].gwe});
      chk(int'(TBL[i].req), "esr_we", {31'd0, esr_we}, {31'd0, TBL[i].ewe});
      chk(int'(TBL[i].req), "ear_we", {31'd0, ear_we}, {31'd0, TBL[i].earwe});
      chk(int'(TBL[i].req), "btr_we", {31'd0, btr_we}, {31'd0, TBL[i].btrwe});
      if (TBL[i].kind != 2'd0) begin
        chk(int'(TBL[i].req), "pc_next", pc_next, TBL[i].epc);
        chk(5, "msr_next (R5 shadow)", msr_next, {16'd0, TBL[i].emsr});
      end
      if (TBL[i].gwe) begin
        chk(int'(TBL[i].req), "gpr_idx", {27'd0, gpr_idx}, {27'd0, TBL[i].gidx});
        chk(int'(TBL[i].req), "gpr_data", gpr_data, TBL[i].gdata);
      end
      if (TBL[i].ewe)   chk(int'(TBL[i].req), "esr_next", esr_next, {16'd0, TBL[i].eesr});
      if (TBL[i].earwe) chk(8, "ear_next", ear_next, ADR0);
      if (TBL[i].btrwe) chk(6, "btr_next", btr_next, BT0);
      idle_inputs();
    end

    // R7 flags cleared by exception only
    @(negedge clk); exc_req = 1; flag_imm = 1;
    @(negedge clk); chk(7, "flags_clr on exception", {31'd0, flags_clr}, 32'd1);
    idle_inputs(); irq_req = 1; cur_msr = 32'h2; flag_imm = 1;
    @(negedge clk); chk(7, "flags_clr on interrupt", {31'd0, flags_clr}, 32'd0);
    idle_inputs(); brk_req = 1; brk_hw = 1;
    @(negedge clk); chk(7, "flags_clr on break", {31'd0, flags_clr}, 32'd0);
    idle_inputs();

    // R9 recursive fault
    @(negedge clk); exc_req = 1; exc_cause = 3'd1; prev_fault = 1;
    @(negedge clk);
    chk(9, "abort raised", {31'd0, abort}, 32'd1);
    chk(9, "no entry on recursive fault", {30'd0, pc_we, msr_we}, 32'd0);
    idle_inputs(); brk_req = 1; brk_hw = 1;
    @(negedge clk);
    chk(9, "abort held", {31'd0, abort}, 32'd1);
    chk(9, "later break blocked", {31'd0, pc_we}, 32'd0);
    idle_inputs();
    // a generic exception with prev_fault set is not recursive
    do_reset();
    @(negedge clk); exc_req = 1; exc_cause = 3'd0; prev_fault = 1;
    @(negedge clk);
    chk(9, "generic exc not recursive", {30'd0, abort, taken_exc}, 32'd1);
    idle_inputs();

    // R12 unknown cause, with a break pending in the same cycle
    do_reset();
    @(negedge clk); exc_req = 1; exc_cause = 3'd5; brk_req = 1; brk_hw = 1; cur_msr = 32'h2802;
    @(negedge clk);
    chk(12, "bad_code raised", {31'd0, bad_code}, 32'd1);
    chk(12, "no write on bad code", {28'd0, pc_we, msr_we, gpr_we, esr_we}, 32'd0);
    idle_inputs();
    @(negedge clk);
    chk(12, "bad_code sticky", {31'd0, bad_code}, 32'd1);
    irq_req = 1; cur_msr = 32'h2;
    @(negedge clk);
    chk(12, "entries continue after bad code", {31'd0, taken_irq}, 32'd1);
    idle_inputs();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule